// File: doc/BRIEF.md
# Pixel-to-LVDS 7:1 Frame Serializer

This block turns one parallel pixel word into a 28-bit frame and sends it out as seven bit periods on each of four data lanes. A fifth lane carries a clock pattern at the pixel rate. Everything runs on a single bit clock at seven times the pixel rate. An internal slot counter marks the frame boundary, and the `take_o` strobe tells the pixel source when its word is sampled. The pixel word is 8-bit red, green and blue plus horizontal sync, vertical sync and data enable.

Two mappings decide which color bits travel on the fourth lane. In the default mapping the two least significant bits of each color go there and the upper six bits fill the lower lanes. In the alternate mapping the two most significant bits go there and the lower six bits fill the lower lanes, in the same slot order. In 18-bit mode the fourth lane stays low for the whole frame. The pixel, the mode and the mapping are all sampled together at the frame boundary.

Top module: `lvds_pixel_packer`

## Requirements
- R1: The block samples one pixel word every seven bit clocks. `take_o` is high for exactly one cycle in seven, and the word present in that cycle is captured at the rising edge that ends the cycle. Its frame is sent in the seven cycles that follow.
- R2: Across a frame's seven slots, `clk_lane_o` follows the pattern high, high, low, low, low, high, high. Slot 0, the first bit of each data lane, lines up with the first high slot.
- R3: Each lane sends its seven frame bits from the lowest frame bit number upward. Lane n carries frame bits 7n to 7n+6.
- R4: With `map_alt`=0, the frame bits are: bits 0-5 red[7:2], bits 6-11 green[7:2], bits 12-17 blue[7:2], bit 18 hsync, bit 19 vsync, bit 20 de, bits 21-22 red[1:0], bits 23-24 green[1:0], bits 25-26 blue[1:0]. Each group is placed lowest bit first.
- R5: With `map_alt`=1, bits 0-17 carry red[5:0], green[5:0] and blue[5:0] in the same group order. Bits 18-20 are unchanged. Bits 21-26 carry red[7:6], green[7:6] and blue[7:6].
- R6: A frame captured with `mode18`=1 keeps lane 3 low in all seven slots, while lanes 0 to 2 follow R4 or R5.
- R7: Frame bit 27, which is slot 6 of lane 3, is always sent as 0.
- R8: Changes to the pixel inputs, `mode18` or `map_alt` outside the capture cycle have no effect on the frame being sent. They take effect only at the next frame boundary.
- R9: Asynchronous active-low reset clears all data lanes to 0, drives `clk_lane_o` high and `take_o` low, and restarts the slot count at slot 0. The first `take_o` follows in the seventh cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| mode18 | input | 1 | 1 = 18-bit color, lane 3 held low |
| map_alt | input | 1 | 0 = color LSBs on lane 3, 1 = color MSBs on lane 3 |
| take_o | output | 1 | High in the cycle whose ending edge captures the pixel word |
| lane_o | output | 4 | Serial data lanes 0 to 3 |
| clk_lane_o | output | 1 | Clock-lane pattern, one period per frame |

## Verification
The hardest case to show from the ports is that a frame already in flight ignores inputs that change after its capture edge. A mapping or mode switch that leaked through would still produce plausible bits. To expose it, the stimulus drives one frame and then, one slot into transmission, replaces every pixel bit, the mode and the mapping with their complements. It then compares the remaining slots against the frame captured earlier. A second hard case is an asynchronous reset that lands in the middle of a frame. The bench applies it between edges and checks that the lanes clear at once, then checks the restart timing of the slot count.

// File: rtl/lvds_pixel_packer.sv
module lvds_pixel_packer (
  input  logic       clk_bit,
  input  logic       rst_n,
  input  logic [7:0] red,
  input  logic [7:0] green,
  input  logic [7:0] blue,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       de,
  input  logic       mode18,
  input  logic       map_alt,
  output logic       take_o,
  output logic [3:0] lane_o,
  output logic       clk_lane_o
);

  localparam int SLOTS   = 7;
  localparam int LANES   = 4;
  localparam int FRAME_W = SLOTS * LANES;
  localparam int PH_W    = $clog2(SLOTS);
  localparam int LO_W    = 6;
  localparam int HI_W    = 2;

  logic [PH_W-1:0]    ph;
  logic [FRAME_W-1:0] frame_d;
  logic [SLOTS-1:0]   sh [LANES];
  logic               m18_q;
  logic               last;

  logic [LO_W-1:0] r_lo, g_lo, b_lo;
  logic [HI_W-1:0] r_hi, g_hi, b_hi;

  assign r_lo = map_alt ? red[5:0]   : red[7:2];
  assign g_lo = map_alt ? green[5:0] : green[7:2];
  assign b_lo = map_alt ? blue[5:0]  : blue[7:2];
  assign r_hi = map_alt ? red[7:6]   : red[1:0];
  assign g_hi = map_alt ? green[7:6] : green[1:0];
  assign b_hi = map_alt ? blue[7:6]  : blue[1:0];

  assign frame_d = {1'b0, mode18 ? 6'b0 : {b_hi, g_hi, r_hi},
                    de, vsync, hsync, b_lo, g_lo, r_lo};

  assign last       = (ph == PH_W'(SLOTS - 1));
  assign take_o     = last;
  assign clk_lane_o = (ph < PH_W'(2)) || (ph > PH_W'(4));

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n)    ph <= '0;
    else if (last) ph <= '0;
    else           ph <= ph + 1'b1;
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n)    m18_q <= 1'b0;
    else if (last) m18_q <= mode18;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)    sh[i] <= '0;
      else if (last) sh[i] <= frame_d[i*SLOTS +: SLOTS];
      else           sh[i] <= sh[i] >> 1;
    end
    assign lane_o[i] = sh[i][0];
  end

  a_r1_phase_wrap: assert property (@(posedge clk_bit) disable iff (!rst_n)
    last |=> ph == '0);
  a_r1_phase_step: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !last |=> ph == $past(ph) + 1'b1);
  a_r1_take_single: assert property (@(posedge clk_bit) disable iff (!rst_n)
    take_o |=> !take_o);
  a_r2_rise_slot: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(clk_lane_o) |-> ph == PH_W'(5));
  a_r2_fall_slot: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $fell(clk_lane_o) |-> ph == PH_W'(2));
  a_r6_lane3_quiet: assert property (@(posedge clk_bit) disable iff (!rst_n)
    m18_q |-> !lane_o[3]);
  a_r7_spare_low: assert property (@(posedge clk_bit) disable iff (!rst_n)
    last |-> !lane_o[3]);
  a_r8_mode_hold: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !last |=> $stable(m18_q));

endmodule

// File: tb/tb_lvds_pixel_packer.sv
module tb_lvds_pixel_packer;
  localparam int CLK_PERIOD = 10;

  logic       clk_bit = 1'b0;
  logic       rst_n   = 1'b0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic       hsync = 0, vsync = 0, de = 0, mode18 = 0, map_alt = 0;
  logic       take_o, clk_lane_o;
  logic [3:0] lane_o;

  int n_chk = 0;
  int n_bad = 0;

  lvds_pixel_packer dut (
    .clk_bit(clk_bit), .rst_n(rst_n), .red(red), .green(green), .blue(blue),
    .hsync(hsync), .vsync(vsync), .de(de), .mode18(mode18), .map_alt(map_alt),
    .take_o(take_o), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
  );

  always #(CLK_PERIOD/2) clk_bit = ~clk_bit;

  // Vector fields: {mode18, map_alt, de, vsync, hsync, red, green, blue}
  localparam logic [28:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'hFF},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'h96},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'h96},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'hC3, 8'h69},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 8'h80, 8'h40},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, 8'hC0, 8'h02}
  };

  function automatic logic [27:0] model(input logic [28:0] v);
    logic [27:0] e;
    logic [7:0] r, g, b;
    int lo, hi;
    e  = '0;
    r  = v[23:16]; g = v[15:8]; b = v[7:0];
    lo = v[27] ? 0 : 2;
    hi = v[27] ? 6 : 0;
    for (int k = 0; k < 6; k++) begin
      e[k]      = r[lo+k];
      e[6 + k]  = g[lo+k];
      e[12 + k] = b[lo+k];
    end
    e[18] = v[24]; e[19] = v[25]; e[20] = v[26];
    if (!v[28]) begin
      for (int k = 0; k < 2; k++) begin
        e[21 + k] = r[hi+k];
        e[23 + k] = g[hi+k];
        e[25 + k] = b[hi+k];
      end
    end
    return e;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Call at a negedge where take_o is high; ends at the next such negedge.
  task automatic send(input logic [28:0] v, input bit scramble, input string force_tag);
    logic [27:0] e;
    string tag;
    e = model(v);
    {mode18, map_alt, de, vsync, hsync, red, green, blue} = v;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_bit);
      if (scramble && k == 1)
        {mode18, map_alt, de, vsync, hsync, red, green, blue} = ~v;
      for (int l = 0; l < 4; l++) begin
        if (force_tag != "")             tag = force_tag;
        else if (scramble && k >= 1)     tag = "R8";
        else if (l == 3 && k == 6)       tag = "R7";
        else if (l == 3 && v[28])        tag = "R6";
        else if (v[27])                  tag = "R5";
        else                             tag = "R4";
        check(lane_o[l], e[l*7 + k], tag, $sformatf("lane%0d slot%0d", l, k));
      end
      check(clk_lane_o, (k < 2) || (k > 4), "R2", $sformatf("clk slot%0d", k));
      check(take_o, k == 6, "R1", $sformatf("take slot%0d", k));
    end
  endtask

  task automatic startup();
    check(take_o, 1'b0, "R9", "take after reset");
    check(clk_lane_o, 1'b1, "R9", "clk lane after reset");
    check(lane_o[0] | lane_o[1] | lane_o[2] | lane_o[3], 1'b0, "R9", "lanes after reset");
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk_bit);
      check(take_o, c == 6, "R9", $sformatf("first take cycle %0d", c));
      check(lane_o[0] | lane_o[1] | lane_o[2] | lane_o[3], 1'b0, "R9", "idle lanes");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_bit);
    rst_n = 1'b1;
    startup();

    for (int i = 0; i < 10; i++) send(VEC[i], 1'b0, "");

    // R3: single bit at frame bit 0 (red[2], default map) then bit 13 (blue[3])
    send({1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 8'h00, 8'h00}, 1'b0, "R3");
    send({1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h08}, 1'b0, "R3");
    // R8: inputs, mode and map inverted one slot into the frame
    send({1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'h96}, 1'b1, "");
    send({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h12, 8'hE7, 8'h5B}, 1'b1, "");
    send(VEC[3], 1'b0, "");

    // R9: asynchronous reset in mid-frame
    {mode18, map_alt, de, vsync, hsync, red, green, blue} = VEC[7];
    repeat (3) @(negedge clk_bit);
    #1 rst_n = 1'b0;
    #1;
    check(lane_o[0] | lane_o[1] | lane_o[2] | lane_o[3], 1'b0, "R9", "lanes in reset");
    check(clk_lane_o, 1'b1, "R9", "clk lane in reset");
    check(take_o, 1'b0, "R9", "take in reset");
    @(negedge clk_bit);
    rst_n = 1'b1;
    startup();
    send(VEC[4], 1'b0, "");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_bit);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule